// File: doc/BRIEF.md
# ADC Power-Mode Sequencing Controller

This block sits on the host side of a serial analog-to-digital converter that can drop into a low-power state by itself after each conversion. Each conversion runs as one 16-clock serial frame. The host drives chip select, serial clock and data out, and reads data in. Every frame writes a control word. That word carries configuration bits that pass straight through, two power-management bits and a reference-enable bit.

The controller follows the converter's power state. The converter goes into its low-power state on the 15th rising serial-clock edge of a frame. It starts to wake when chip select rises. The controller then waits a power-up time that depends on the mode before it lowers chip select for the next conversion. Requests that arrive during a frame or during the wait are held and served as soon as the wait ends. Each received word comes out with a one-cycle valid pulse and a flag that says whether the converter was known to be fully awake when the frame began.

Top module: `adc_pwr_seq`

## Requirements
- R1: `adc_sclk` is high whenever `adc_cs_n` is high. Each frame has exactly 16 rising edges of `adc_sclk` while `adc_cs_n` is low, with SCLK_HALF system clocks per half period. `adc_mosi` sends the control word most significant bit first and is stable at each falling edge.
- R2: The control word has bit 15 = 1, bits 14..6 = `cfg_bits`, bits 5..4 = the power bits, bit 3 = reference enable and bits 2..0 = 0.
- R3: The power bits are taken from `mode_sel`: 2'b10 is deep sleep (shutdown), 2'b01 is light sleep (standby) and 2'b00 is full power. The reserved value 2'b11 is written as 2'b00.
- R4: When the written power bits are 2'b01, bit 3 is written as 1 whatever `ref_en` is. In all other cases bit 3 follows `ref_en`.
- R5: `adc_cs_n` stays low through the 15th and 16th rising edges and rises only after the 16th.
- R6: If a request is pending when `adc_cs_n` rises, the next falling edge of `adc_cs_n` comes exactly W+2 clocks later. W is CLK_MHZ*SHUT_WAKE_US after deep sleep was written, ceil(CLK_MHZ*STBY_WAKE_NS/1000) after light sleep was written, and 0 otherwise. With no request pending, the gap is never shorter than W+2.
- R7: A `conv_req` pulse that arrives during a frame or during the wait is held and served later. Several pulses before a frame starts merge into a single frame.
- R8: `busy` is high while a request is pending, while a frame is running and while the power-up wait counts. It is low once all three have ended.
- R9: `res_valid` is a one-cycle pulse one clock after `adc_cs_n` rises. `res_data` then holds the 16 bits sampled on `adc_miso` at the rising edges, first bit in the MSB.
- R10: `res_ok` is 0 for the first frame after reset, because the converter state is unknown. It is 1 for every frame that starts after a completed wait.
- R11: During and just after reset, `adc_cs_n`=1, `adc_sclk`=1, `busy`=0 and `res_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Requested power mode, sampled at frame start |
| cfg_bits | input | 9 | Pass-through configuration bits, sampled at frame start |
| ref_en | input | 1 | Requested reference enable, sampled at frame start |
| conv_req | input | 1 | One-cycle conversion request |
| busy | output | 1 | Request pending, frame running or power-up wait active |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | 16 | Received converter word |
| res_ok | output | 1 | Converter was fully awake at frame start |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_mosi | output | 1 | Control word to converter |
| adc_miso | input | 1 | Result data from converter |

## Verification
The bench builds the block with CLK_MHZ=100, SHUT_WAKE_US=2 and STBY_WAKE_NS=700. This makes the deep-sleep wait 200 clocks and the light-sleep wait 70 clocks, so the bench can measure both waits exactly within a short run, together with the zero wait of full power. SCLK_HALF=2 keeps frames near 70 clocks. The bench issues back-to-back requests in every mode and the reserved mode, so each chip-select gap is compared with the wait chosen by the previous frame's written bits. A second reset checks that the result flag falls back to invalid.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  // Control word layout as decoded by the converter
  localparam int WORD_W  = 16;
  localparam int CFG_W   = 9;
  localparam int WR_BIT  = 15;
  localparam int CFG_LSB = 6;
  localparam int PM_LSB  = 4;
  localparam int REF_BIT = 3;

  typedef enum logic [1:0] {
    PM_FULL  = 2'b00,
    PM_LIGHT = 2'b01,
    PM_DEEP  = 2'b10,
    PM_RSVD  = 2'b11
  } pm_e;

  typedef enum logic [2:0] {
    CV_UNKNOWN,
    CV_AWAKE,
    CV_DEEP,
    CV_LIGHT,
    CV_WAKING
  } cv_state_e;

  function automatic logic [1:0] pm_written(input logic [1:0] mode);
    return (mode == PM_RSVD) ? PM_FULL : mode;
  endfunction

  function automatic logic [WORD_W-1:0] build_word(
    input logic [CFG_W-1:0] cfg,
    input logic [1:0]       pm,
    input logic             ref_on
  );
    logic [WORD_W-1:0] w;
    w                  = '0;
    w[WR_BIT]          = 1'b1;
    w[CFG_LSB +: CFG_W] = cfg;
    w[PM_LSB +: 2]     = pm;
    w[REF_BIT]         = ref_on | (pm == PM_LIGHT);
    return w;
  endfunction

endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame #(
  parameter int WORD_W    = 16,
  parameter int SCLK_HALF = 2,
  parameter int LP_EDGE   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              active,
  output logic              lp_edge,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);

  localparam int HC_W  = $clog2(2 * WORD_W);
  localparam int DIV_W = $clog2(SCLK_HALF + 1);
  localparam logic [HC_W-1:0]  HC_LAST = HC_W'(2 * WORD_W - 1);
  localparam logic [HC_W-1:0]  HC_LP   = HC_W'(2 * LP_EDGE - 1);
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(SCLK_HALF - 1);

  logic [DIV_W-1:0]  div_cnt;
  logic [HC_W-1:0]   half_cnt;
  logic              tail;
  logic [WORD_W-1:0] sh_tx;
  logic [WORD_W-1:0] sh_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      tail     <= 1'b0;
      div_cnt  <= '0;
      half_cnt <= '0;
      sh_tx    <= '0;
      sh_rx    <= '0;
      lp_edge  <= 1'b0;
      done     <= 1'b0;
    end else begin
      lp_edge <= 1'b0;
      done    <= 1'b0;
      if (!active) begin
        if (start) begin
          active   <= 1'b1;
          cs_n     <= 1'b0;
          sclk     <= 1'b1;
          tail     <= 1'b0;
          div_cnt  <= '0;
          half_cnt <= '0;
          sh_tx    <= tx_word;
        end
      end else if (div_cnt == DIV_END) begin
        div_cnt <= '0;
        if (tail) begin
          active <= 1'b0;
          cs_n   <= 1'b1;
          done   <= 1'b1;
        end else if (!half_cnt[0]) begin
          sclk     <= 1'b0;
          half_cnt <= half_cnt + 1'b1;
        end else begin
          sclk  <= 1'b1;
          sh_rx <= {sh_rx[WORD_W-2:0], miso};
          sh_tx <= {sh_tx[WORD_W-2:0], 1'b0};
          if (half_cnt == HC_LP) lp_edge <= 1'b1;
          if (half_cnt == HC_LAST) tail <= 1'b1;
          else                     half_cnt <= half_cnt + 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign mosi    = sh_tx[WORD_W-1];
  assign rx_word = sh_rx;

endmodule

// File: rtl/adc_wake_timer.sv
module adc_wake_timer #(
  parameter int SHUT_CYC = 50000,
  parameter int STBY_CYC = 70
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] pm,
  output logic       ready,
  output logic       counting
);
  import adc_pwr_pkg::*;

  localparam int MAX_CYC = (SHUT_CYC > STBY_CYC) ? SHUT_CYC : STBY_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 2);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      case (pm)
        PM_DEEP:  cnt <= CNT_W'(SHUT_CYC);
        PM_LIGHT: cnt <= CNT_W'(STBY_CYC);
        default:  cnt <= '0;
      endcase
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign ready    = (cnt == '0);
  assign counting = (cnt != '0);

endmodule

// File: rtl/adc_pwr_track.sv
module adc_pwr_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       lp_edge,
  input  logic [1:0] frame_pm,
  input  logic       cs_rise,
  input  logic       wait_ready,
  output logic       powered
);
  import adc_pwr_pkg::*;

  cv_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CV_UNKNOWN;
    end else if (lp_edge) begin
      case (frame_pm)
        PM_DEEP:  state <= CV_DEEP;
        PM_LIGHT: state <= CV_LIGHT;
        default:  state <= CV_AWAKE;
      endcase
    end else if (cs_rise) begin
      if (state == CV_DEEP || state == CV_LIGHT) state <= CV_WAKING;
    end else if (state == CV_WAKING && wait_ready) begin
      state <= CV_AWAKE;
    end
  end

  assign powered = (state == CV_AWAKE) || (state == CV_WAKING && wait_ready && !cs_rise);

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int CLK_MHZ      = 100,
  parameter int SHUT_WAKE_US = 500,
  parameter int STBY_WAKE_NS = 700,
  parameter int SCLK_HALF    = 2,
  parameter int LP_EDGE      = 15
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  mode_sel,
  input  logic [8:0]  cfg_bits,
  input  logic        ref_en,
  input  logic        conv_req,
  output logic        busy,
  output logic        res_valid,
  output logic [15:0] res_data,
  output logic        res_ok,
  output logic        adc_cs_n,
  output logic        adc_sclk,
  output logic        adc_mosi,
  input  logic        adc_miso
);
  import adc_pwr_pkg::*;

  localparam int SHUT_CYC = CLK_MHZ * SHUT_WAKE_US;
  localparam int STBY_CYC = (CLK_MHZ * STBY_WAKE_NS + 999) / 1000;

  logic              pending;
  logic              frm_active;
  logic              frm_lp_edge;
  logic              frm_done;
  logic [WORD_W-1:0] frm_rx;
  logic [WORD_W-1:0] frm_tx;
  logic              wait_ready;
  logic              wait_busy;
  logic              powered;
  logic              go;
  logic [1:0]        pm_lat;
  logic              ok_lat;

  assign frm_tx = build_word(cfg_bits, pm_written(mode_sel), ref_en);
  assign go     = pending && wait_ready && !frm_active && !frm_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      pm_lat    <= PM_FULL;
      ok_lat    <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_ok    <= 1'b0;
    end else begin
      if (go) begin
        pending <= conv_req;
        pm_lat  <= pm_written(mode_sel);
        ok_lat  <= powered;
      end else if (conv_req) begin
        pending <= 1'b1;
      end
      res_valid <= frm_done;
      if (frm_done) begin
        res_data <= frm_rx;
        res_ok   <= ok_lat;
      end
    end
  end

  assign busy = pending | frm_active | frm_done | wait_busy;

  adc_spi_frame #(
    .WORD_W   (WORD_W),
    .SCLK_HALF(SCLK_HALF),
    .LP_EDGE  (LP_EDGE)
  ) u_frame (
    .clk    (clk),
    .rst    (rst),
    .start  (go),
    .tx_word(frm_tx),
    .miso   (adc_miso),
    .cs_n   (adc_cs_n),
    .sclk   (adc_sclk),
    .mosi   (adc_mosi),
    .active (frm_active),
    .lp_edge(frm_lp_edge),
    .done   (frm_done),
    .rx_word(frm_rx)
  );

  adc_wake_timer #(
    .SHUT_CYC(SHUT_CYC),
    .STBY_CYC(STBY_CYC)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (frm_done),
    .pm      (pm_lat),
    .ready   (wait_ready),
    .counting(wait_busy)
  );

  adc_pwr_track u_track (
    .clk       (clk),
    .rst       (rst),
    .lp_edge   (frm_lp_edge),
    .frame_pm  (pm_lat),
    .cs_rise   (frm_done),
    .wait_ready(wait_ready),
    .powered   (powered)
  );

endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk (
  input logic clk,
  input logic rst,
  input logic conv_req,
  input logic busy,
  input logic res_valid,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic wait_ready,
  input logic wait_busy
);

  // R1: serial clock idles high outside a frame
  a_r1_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> adc_sclk);

  // R6: a frame never starts while the power-up wait is running
  a_r6_start_after_wait: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> $past(wait_ready));

  // R7: a request is never dropped silently
  a_r7_req_makes_busy: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> busy);

  // R8: busy covers the whole power-up wait
  a_r8_busy_in_wait: assert property (@(posedge clk) disable iff (rst)
    wait_busy |-> busy);

  // R9: result strobe is a single cycle
  a_r9_valid_single: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R9: result strobe follows the chip-select rise
  a_r9_valid_after_cs: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cs_n) |=> res_valid);

endmodule

bind adc_pwr_seq adc_pwr_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .conv_req  (conv_req),
  .busy      (busy),
  .res_valid (res_valid),
  .adc_cs_n  (adc_cs_n),
  .adc_sclk  (adc_sclk),
  .wait_ready(wait_ready),
  .wait_busy (wait_busy)
);

// File: tb/test_adc_pwr_seq.sv
`timescale 1ns/1ps
module test_adc_pwr_seq;

  localparam int CLK_MHZ   = 100;
  localparam int SHUT_US   = 2;
  localparam int STBY_NS   = 700;
  localparam int HALF      = 2;
  localparam int SHUT_WAIT = CLK_MHZ * SHUT_US;
  localparam int STBY_WAIT = (CLK_MHZ * STBY_NS + 999) / 1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_sel = 2'b00;
  logic [8:0]  cfg_bits = '0;
  logic        ref_en = 1'b0;
  logic        conv_req = 1'b0;
  logic        busy;
  logic        res_valid;
  logic [15:0] res_data;
  logic        res_ok;
  logic        adc_cs_n;
  logic        adc_sclk;
  logic        adc_mosi;
  logic        adc_miso = 1'b0;

  always #5 clk = ~clk;

  adc_pwr_seq #(
    .CLK_MHZ(CLK_MHZ), .SHUT_WAKE_US(SHUT_US), .STBY_WAKE_NS(STBY_NS),
    .SCLK_HALF(HALF), .LP_EDGE(15)
  ) i_adc_pwr_seq (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .cfg_bits(cfg_bits),
    .ref_en(ref_en), .conv_req(conv_req), .busy(busy), .res_valid(res_valid),
    .res_data(res_data), .res_ok(res_ok), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_mosi(adc_mosi), .adc_miso(adc_miso)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct { logic [15:0] w; logic ok; } res_t;
  logic [15:0] ctl_q[$];
  res_t        res_q[$];

  // converter model state
  int          frame_idx = 0;
  bit          in_frame = 0;
  int          rises = 0;
  int          bit_i = 0;
  logic [15:0] drv_word = '0;
  logic [15:0] rx = '0;
  logic [1:0]  prev_pm = 2'b00;
  realtime     t_rise = 0;
  bit          req_since_start = 0;
  bit          req_at_rise = 0;

  function automatic int wake_of(input logic [1:0] pm);
    if (pm == 2'b10) return SHUT_WAIT;
    if (pm == 2'b01) return STBY_WAIT;
    return 0;
  endfunction

  function automatic logic [15:0] exp_word(input logic [1:0] mode, input logic [8:0] cfg,
                                           input logic rf);
    logic [1:0] pm;
    pm = (mode == 2'b11) ? 2'b00 : mode;
    return {1'b1, cfg, pm, (rf | (pm == 2'b01)), 3'b000};
  endfunction

  always @(negedge adc_cs_n) begin
    if (!rst) begin
      int gap;
      res_t r;
      in_frame = 1;
      rises = 0;
      drv_word = 16'hC3A5 ^ 16'(frame_idx * 16'h1357);
      bit_i = 15;
      adc_miso = drv_word[15];
      r.w = drv_word;
      r.ok = (frame_idx != 0);
      res_q.push_back(r);
      if (frame_idx != 0) begin
        gap = int'(($realtime - t_rise) / 10.0);
        if (req_at_rise)
          check(gap == wake_of(prev_pm) + 2, "R6", "cs gap", gap, wake_of(prev_pm) + 2);
        else
          check(gap >= wake_of(prev_pm) + 2, "R6", "cs gap minimum", gap, wake_of(prev_pm) + 2);
      end
      frame_idx++;
      req_since_start = 0;
    end
  end

  always @(negedge adc_sclk) if (adc_cs_n === 1'b0) rx = {rx[14:0], adc_mosi};

  always @(posedge adc_sclk) begin
    if (adc_cs_n === 1'b0) begin
      rises++;
      bit_i--;
      if (bit_i >= 0) adc_miso = drv_word[bit_i];
    end
  end

  always @(posedge adc_cs_n) begin
    if (in_frame) begin
      logic [15:0] e;
      in_frame = 0;
      check(rises == 16, "R1 R5", "rising edges in frame", rises, 16);
      e = (ctl_q.size() > 0) ? ctl_q.pop_front() : 16'hxxxx;
      check(rx === e, "R2 R3 R4", "control word", rx, e);
      prev_pm = rx[5:4];
      t_rise = $realtime;
      req_at_rise = req_since_start;
    end
  end

  // scoreboard monitor
  bit last_valid = 0;
  int n_results = 0;
  always @(negedge clk) begin
    if (!rst) begin
      check(!(res_valid && last_valid), "R9", "valid pulse width", 2, 1);
      if (res_valid) begin
        res_t r;
        n_results++;
        if (res_q.size() > 0) begin
          r = res_q.pop_front();
          check(res_data == r.w, "R9", "result data", res_data, r.w);
          check(res_ok == r.ok, "R10", "result ok flag", res_ok, r.ok);
        end else begin
          check(0, "R9", "unexpected result", 1, 0);
        end
      end
      if (adc_cs_n) checks++;
      if (adc_cs_n && !adc_sclk) begin
        errors++;
        $display("FAIL R1 sclk low while idle: actual=0 expected=1");
      end
    end
    last_valid = res_valid;
  end

  task automatic pulse_req();
    @(negedge clk) conv_req = 1'b1;
    req_since_start = 1;
    @(negedge clk) conv_req = 1'b0;
  endtask

  task automatic send(input logic [1:0] mode, input logic [8:0] cfg, input logic rf);
    @(negedge clk);
    mode_sel = mode; cfg_bits = cfg; ref_en = rf;
    ctl_q.push_back(exp_word(mode, cfg, rf));
    pulse_req();
    check(busy == 1'b1, "R7 R8", "busy after request", busy, 1);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    check(adc_cs_n == 1'b1 && adc_sclk == 1'b1, "R11", "lines idle in reset",
          {adc_cs_n, adc_sclk}, 2'b11);
    check(busy == 1'b0 && res_valid == 1'b0, "R11", "busy/valid in reset",
          {busy, res_valid}, 0);
    frame_idx = 0; ctl_q.delete(); res_q.delete(); in_frame = 0;
    rst = 1'b0;
    @(negedge clk);
    check(adc_cs_n == 1'b1 && busy == 1'b0, "R11", "idle after reset", {adc_cs_n, busy}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    // first frame from unknown state, writes deep sleep
    send(2'b10, 9'h155, 1'b0);
    @(negedge adc_cs_n);
    // light sleep with ref requested off: written as on (R4); extra pulse merges (R7)
    send(2'b01, 9'h0AA, 1'b0);
    pulse_req();
    @(negedge adc_cs_n);
    send(2'b00, 9'h1FF, 1'b1);
    @(negedge adc_cs_n);
    send(2'b11, 9'h003, 1'b0);   // reserved mode written as full power (R3)
    @(negedge adc_cs_n);
    send(2'b10, 9'h100, 1'b1);
    @(negedge adc_cs_n);
    @(posedge adc_cs_n);
    repeat (100) @(negedge clk);
    check(busy == 1'b1, "R8", "busy during deep-sleep wait", busy, 1);
    repeat (SHUT_WAIT) @(negedge clk);
    check(busy == 1'b0, "R8", "idle after wait", busy, 0);
    check(frame_idx == 5, "R7", "frame count with merged request", frame_idx, 5);
    // request after the wait has ended
    send(2'b01, 9'h011, 1'b1);
    @(negedge adc_cs_n);
    @(posedge adc_cs_n);
    repeat (STBY_WAIT + 10) @(negedge clk);
    check(res_q.size() == 0, "R9", "all results delivered", res_q.size(), 0);
    // second reset: flag returns to invalid for the first frame
    do_reset();
    send(2'b00, 9'h0F0, 1'b0);
    @(negedge adc_cs_n);
    send(2'b00, 9'h00F, 1'b0);
    @(negedge adc_cs_n);
    @(posedge adc_cs_n);
    repeat (10) @(negedge clk);
    check(res_q.size() == 0 && ctl_q.size() == 0, "R10", "queues drained",
          res_q.size() + ctl_q.size(), 0);
    check(n_results == 8, "R9", "result pulses", n_results, 8);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule